// File: doc/BRIEF.md
# Near Branch Target Calculator

This block works out the new instruction pointer for a near or short branch and decides whether the branch may retire. It supports two target forms. The relative form adds a signed 8, 16 or 32-bit displacement to the address of the instruction after the branch. The absolute form takes a register or memory operand as the new pointer, with no addition.

The result is then shaped and checked. Outside 64-bit mode it is trimmed to the operand size and compared with the code-segment limit. In 64-bit mode it must be canonical, and only the branch forms legal in that mode are accepted.

The caller presents a decoded branch with a one-cycle strobe. One clock later the block either commits the new pointer, pulsing a commit strobe, or raises a general-protection fault (error code 0) and leaves the pointer unchanged. The block holds the architectural pointer in a register of its own.

Top module: `nbt_top`

## Requirements
- R1: A relative branch (`br_rel`=1) sign-extends the low 8, 16 or 32 bits of `br_operand` (`br_dw` = 0, 1, 2 respectively) and adds them to `seq_ip`. Bits of the operand above the selected width have no effect. An 8-bit displacement covers -128 to +127.
- R2: An absolute branch (`br_rel`=0) takes `br_operand` as the target with no addition.
- R3: Outside 64-bit mode with `br_osz`=0 (16-bit), the committed pointer has bits 63..16 cleared. The limit check uses the 32-bit target before this clearing.
- R4: When `long_act`=0, or when `long_act`=1 and `compat_act`=1, a 32-bit target greater than `cs_limit` faults. A target equal to the limit commits. In 64-bit mode (`long_act`=1, `compat_act`=0) the limit is ignored.
- R5: In 64-bit mode the target must be canonical, meaning bits 63 down to 47 are all equal; otherwise the branch faults.
- R6: In 64-bit mode the operation size is 64 bits and `br_osz` does not affect a relative branch. A relative branch with `br_dw`=1 faults, and an absolute branch with `br_osz` other than 2 faults.
- R7: Outside 64-bit mode, `br_osz`=2 (64-bit) or 3 (reserved) faults. In every mode a relative branch with `br_dw`=3 (reserved) faults.
- R8: When a fault is raised, `ip_q` keeps its previous value and `ip_commit` stays low. Commit and fault are never high together.
- R9: `ip_commit` or `gp_fault` is a single-cycle pulse in the clock after the `br_vld` strobe. Neither output moves, and neither does `ip_q`, without a strobe.
- R10: After reset, `ip_q` is 0 and `ip_commit` and `gp_fault` are low.
- R11: Outside 64-bit mode, target arithmetic is 32 bits wide and wraps. Bits 63..32 of `seq_ip` and of the committed pointer are ignored and zero respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_vld | input | 1 | One-cycle strobe presenting a branch |
| seq_ip | input | 64 | Address of the instruction following the branch |
| br_operand | input | 64 | Displacement (relative) or target (absolute) |
| br_osz | input | 2 | Operand size: 0=16, 1=32, 2=64, 3=reserved |
| br_rel | input | 1 | 1 = relative form, 0 = absolute form |
| br_dw | input | 2 | Displacement width: 0=8, 1=16, 2=32, 3=reserved |
| cs_limit | input | 32 | Code-segment limit (inclusive) |
| long_act | input | 1 | Long mode active |
| compat_act | input | 1 | Target runs in compatibility mode |
| ip_q | output | 64 | Architectural instruction pointer |
| ip_commit | output | 1 | Pulse: new pointer committed |
| gp_fault | output | 1 | Pulse: general-protection fault, error code 0 |

## Verification
Two checks can act on the same branch: the segment-limit check and the 16-bit truncation. An absolute 16-bit target of 0x12345 can be tested against limits on either side of the full 32-bit value. Against a limit of 0xFFFF the branch must fault with the pointer held, even though the truncated value 0x2345 would fit. Against 0xFFFFF it must commit 0x2345.

The legality filter and the canonical check can also both apply in 64-bit mode. Vectors on each side of the bit-47 boundary show that each one raises the fault independently.

// File: rtl/nbt_pkg.sv
// Package: shared encodings for the near branch target calculator.
// Assumes: 2-bit size and width selects as documented in the port table.
package nbt_pkg;
    typedef enum logic [1:0] {
        OSZ_16  = 2'd0,
        OSZ_32  = 2'd1,
        OSZ_64  = 2'd2,
        OSZ_RSV = 2'd3
    } osz_e;

    typedef enum logic [1:0] {
        DW_8   = 2'd0,
        DW_16  = 2'd1,
        DW_32  = 2'd2,
        DW_RSV = 2'd3
    } dw_e;
endpackage

// File: rtl/nbt_disp_ext.sv
// Module: sign-extends the selected low slice of the operand to the full
// address width. Assumes ADDR_W >= 32. A reserved width yields zero; the
// guard stage faults that case, so the value is never committed.
module nbt_disp_ext
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [31:0]       raw,
    input  logic [1:0]        dw,
    output logic [ADDR_W-1:0] disp
);
    localparam int EXT8  = ADDR_W - 8;
    localparam int EXT16 = ADDR_W - 16;
    localparam int EXT32 = ADDR_W - 32;

    logic [ADDR_W-1:0] d8, d16, d32;

    // widen each candidate slice by replicating its sign bit
    always_comb begin
        d8  = {{EXT8{raw[7]}},   raw[7:0]};
        d16 = {{EXT16{raw[15]}}, raw[15:0]};
        d32 = {{EXT32{raw[31]}}, raw[31:0]};
    end

    // pick the slice named by the width select
    always_comb begin
        unique case (dw_e'(dw))
            DW_8:    disp = d8;
            DW_16:   disp = d16;
            DW_32:   disp = d32;
            default: disp = '0;
        endcase
    end
endmodule

// File: rtl/nbt_target.sv
// Module: forms the raw branch target in both the full-width and the
// 32-bit legacy domain. Assumes ADDR_W >= EIP_W. Legacy arithmetic wraps
// at EIP_W bits and ignores the upper bits of the sequential address.
module nbt_target #(
    parameter int ADDR_W = 64,
    parameter int EIP_W  = 32
) (
    input  logic [ADDR_W-1:0] seq_ip,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] disp,
    input  logic              rel,
    output logic [ADDR_W-1:0] tgt_wide,
    output logic [EIP_W-1:0]  tgt_leg
);
    logic [ADDR_W-1:0] sum_wide;
    logic [EIP_W-1:0]  sum_leg;

    // relative sums in each address domain
    always_comb begin
        sum_wide = seq_ip + disp;
        sum_leg  = seq_ip[EIP_W-1:0] + disp[EIP_W-1:0];
    end

    // choose relative sum or absolute operand
    always_comb begin
        tgt_wide = rel ? sum_wide : operand;
        tgt_leg  = rel ? sum_leg  : operand[EIP_W-1:0];
    end
endmodule

// File: rtl/nbt_guard.sv
// Module: decides legality of the branch form, runs the limit and
// canonical checks, and shapes the final pointer. Purely combinational.
// Assumes VA_W <= ADDR_W; when they are equal every address is canonical.
module nbt_guard
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int EIP_W  = 32,
    parameter int VA_W   = 48,
    parameter int LIM_W  = 32
) (
    input  logic [ADDR_W-1:0] tgt_wide,
    input  logic [EIP_W-1:0]  tgt_leg,
    input  logic [LIM_W-1:0]  cs_limit,
    input  logic [1:0]        osz,
    input  logic [1:0]        dw,
    input  logic              rel,
    input  logic              long_act,
    input  logic              compat_act,
    output logic              fault,
    output logic [ADDR_W-1:0] new_ip
);
    localparam int HALF_W = EIP_W / 2;
    localparam int TOP_W  = ADDR_W - VA_W + 1;

    logic mode64;
    logic bad_form;
    logic over_limit;
    logic canon;
    logic [ADDR_W-1:0] leg_shaped;

    // 64-bit mode is long mode without compatibility
    always_comb mode64 = long_act & ~compat_act;

    // reject forms illegal in the current mode
    always_comb begin
        bad_form = 1'b0;
        if (rel && dw_e'(dw) == DW_RSV) bad_form = 1'b1;
        if (mode64) begin
            if (rel && dw_e'(dw) == DW_16)   bad_form = 1'b1;
            if (!rel && osz_e'(osz) != OSZ_64) bad_form = 1'b1;
        end else begin
            if (osz_e'(osz) == OSZ_64 || osz_e'(osz) == OSZ_RSV) bad_form = 1'b1;
        end
    end

    // limit check on the untrimmed legacy target
    always_comb over_limit = !mode64 &&
        ({{(LIM_W > EIP_W ? LIM_W - EIP_W : 0){1'b0}}, tgt_leg} > {{(EIP_W > LIM_W ? EIP_W - LIM_W : 0){1'b0}}, cs_limit});

    // canonical test of the upper address bits, if any exist
    generate
        if (VA_W < ADDR_W) begin : g_canon
            logic [TOP_W-1:0] top_bits;
            always_comb top_bits = tgt_wide[ADDR_W-1:VA_W-1];
            // all ones or all zeros above the virtual address
            always_comb canon = (&top_bits) | ~(|top_bits);
        end else begin : g_flat
            // full-width virtual space: every address is canonical
            always_comb canon = 1'b1;
        end
    endgenerate

    // trim the legacy target to the operand size
    always_comb begin
        if (osz_e'(osz) == OSZ_16)
            leg_shaped = {{(ADDR_W-HALF_W){1'b0}}, tgt_leg[HALF_W-1:0]};
        else
            leg_shaped = {{(ADDR_W-EIP_W){1'b0}}, tgt_leg};
    end

    // combine fault sources and select the pointer for the mode
    always_comb begin
        fault  = bad_form | over_limit | (mode64 & ~canon);
        new_ip = mode64 ? tgt_wide : leg_shaped;
    end
endmodule

// File: rtl/nbt_top.sv
// Module: near branch target calculator top. Registers the outcome of a
// strobed branch: commits the new pointer or flags a general-protection
// fault one clock later. Assumes br_vld is a single-cycle strobe and the
// decode inputs are stable while it is high. Synchronous active-low reset.
module nbt_top #(
    parameter int ADDR_W = 64,
    parameter int EIP_W  = 32,
    parameter int VA_W   = 48,
    parameter int LIM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_vld,
    input  logic [ADDR_W-1:0] seq_ip,
    input  logic [ADDR_W-1:0] br_operand,
    input  logic [1:0]        br_osz,
    input  logic              br_rel,
    input  logic [1:0]        br_dw,
    input  logic [LIM_W-1:0]  cs_limit,
    input  logic              long_act,
    input  logic              compat_act,
    output logic [ADDR_W-1:0] ip_q,
    output logic              ip_commit,
    output logic              gp_fault
);
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] tgt_wide;
    logic [EIP_W-1:0]  tgt_leg;
    logic              fault_c;
    logic [ADDR_W-1:0] new_ip_c;

    nbt_disp_ext #(.ADDR_W(ADDR_W)) u_ext (
        .raw  (br_operand[31:0]),
        .dw   (br_dw),
        .disp (disp)
    );

    nbt_target #(.ADDR_W(ADDR_W), .EIP_W(EIP_W)) u_tgt (
        .seq_ip   (seq_ip),
        .operand  (br_operand),
        .disp     (disp),
        .rel      (br_rel),
        .tgt_wide (tgt_wide),
        .tgt_leg  (tgt_leg)
    );

    nbt_guard #(.ADDR_W(ADDR_W), .EIP_W(EIP_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_grd (
        .tgt_wide   (tgt_wide),
        .tgt_leg    (tgt_leg),
        .cs_limit   (cs_limit),
        .osz        (br_osz),
        .dw         (br_dw),
        .rel        (br_rel),
        .long_act   (long_act),
        .compat_act (compat_act),
        .fault      (fault_c),
        .new_ip     (new_ip_c)
    );

    // pointer register: loads only on a strobe without fault
    always_ff @(posedge clk) begin
        if (!rst_n)                  ip_q <= '0;
        else if (br_vld && !fault_c) ip_q <= new_ip_c;
    end

    // outcome pulses, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_commit <= 1'b0;
            gp_fault  <= 1'b0;
        end else begin
            ip_commit <= br_vld & ~fault_c;
            gp_fault  <= br_vld &  fault_c;
        end
    end
endmodule

// File: rtl/nbt_sva.sv
// Checker: temporal properties of the branch calculator outputs.
module nbt_sva #(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_vld,
    input logic [1:0]        br_osz,
    input logic              long_act,
    input logic              compat_act,
    input logic [ADDR_W-1:0] ip_q,
    input logic              ip_commit,
    input logic              gp_fault
);
    // R8
    excl_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ip_commit && gp_fault));

    // R8
    hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> ip_q == $past(ip_q));

    // R9
    strobe_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_vld |=> (ip_commit || gp_fault));

    // R9
    quiet_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_vld |=> (!ip_commit && !gp_fault && $stable(ip_q)));

    // R5
    canon_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_vld && long_act && !compat_act) |=>
            (!ip_commit || (&ip_q[ADDR_W-1:VA_W-1]) || !(|ip_q[ADDR_W-1:VA_W-1])));

    // R11
    legacy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_vld && !(long_act && !compat_act)) |=> (!ip_commit || ip_q[ADDR_W-1:32] == '0));

    // R3
    half_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_vld && !(long_act && !compat_act) && br_osz == 2'd0) |=>
            (!ip_commit || ip_q[ADDR_W-1:16] == '0));
endmodule

bind nbt_top nbt_sva #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_vld     (br_vld),
    .br_osz     (br_osz),
    .long_act   (long_act),
    .compat_act (compat_act),
    .ip_q       (ip_q),
    .ip_commit  (ip_commit),
    .gp_fault   (gp_fault)
);

// File: tb/tb_nbt_top.sv
// Bench: vector table walked by one loop, then directed reset and idle tests.
module tb_nbt_top;
    typedef struct packed {
        logic [7:0]  req;
        logic        lm;
        logic        cm;
        logic        rel;
        logic [1:0]  dw;
        logic [1:0]  osz;
        logic [63:0] nip;
        logic [63:0] opnd;
        logic [31:0] lim;
        logic        xflt;
        logic [63:0] xip;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        // R1 legacy rel8 +127
        '{8'd1, 1'b0,1'b0,1'b1,2'd0,2'd1, 64'h1000, 64'h7F, 32'hFFFFF, 1'b0, 64'h107F},
        // R1 rel8 -128, high operand bits ignored
        '{8'd1, 1'b0,1'b0,1'b1,2'd0,2'd1, 64'h1000, 64'hAAAAAAAAAAAAAA80, 32'hFFFFF, 1'b0, 64'h0F80},
        // R3 rel16 with 16-bit size, wraps to low half
        '{8'd3, 1'b0,1'b0,1'b1,2'd1,2'd0, 64'hFFF0, 64'h0020, 32'hFFFFF, 1'b0, 64'h10},
        // R1 rel32 negative
        '{8'd1, 1'b0,1'b0,1'b1,2'd2,2'd1, 64'h2000, 64'hFFFFF000, 32'hFFFFF, 1'b0, 64'h1000},
        // R2 absolute 32
        '{8'd2, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0, 64'h45678, 32'hFFFFF, 1'b0, 64'h45678},
        // R3 absolute 16 trims upper bits
        '{8'd3, 1'b0,1'b0,1'b0,2'd0,2'd0, 64'h0, 64'h12345, 32'hFFFFF, 1'b0, 64'h2345},
        // R4 one past limit
        '{8'd4, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0, 64'h100000, 32'hFFFFF, 1'b1, 64'h2345},
        // R4 exactly at limit
        '{8'd4, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0, 64'hFFFFF, 32'hFFFFF, 1'b0, 64'hFFFFF},
        // R3 limit checked before trimming
        '{8'd3, 1'b0,1'b0,1'b0,2'd0,2'd0, 64'h0, 64'h12345, 32'hFFFF, 1'b1, 64'hFFFFF},
        // R11 32-bit wrap, upper seq bits ignored
        '{8'd11, 1'b0,1'b0,1'b1,2'd2,2'd1, 64'hDEAD0000FFFFFFF0, 64'h20, 32'hFFFFFFFF, 1'b0, 64'h10},
        // R7 legacy 64-bit size
        '{8'd7, 1'b0,1'b0,1'b0,2'd0,2'd2, 64'h0, 64'h100, 32'hFFFFF, 1'b1, 64'h10},
        // R7 reserved displacement width
        '{8'd7, 1'b0,1'b0,1'b1,2'd3,2'd1, 64'h100, 64'h4, 32'hFFFFF, 1'b1, 64'h10},
        // R6 64-bit rel8, size select ignored
        '{8'd6, 1'b1,1'b0,1'b1,2'd0,2'd0, 64'h100000000, 64'h05, 32'h0, 1'b0, 64'h100000005},
        // R5 rel32 crosses into non-canonical
        '{8'd5, 1'b1,1'b0,1'b1,2'd2,2'd2, 64'h00007FFFFFFFFFF0, 64'h10, 32'h0, 1'b1, 64'h100000005},
        // R5 rel32 negative, canonical high half
        '{8'd5, 1'b1,1'b0,1'b1,2'd2,2'd2, 64'hFFFF800000000100, 64'hFFFFFFE0, 32'h0, 1'b0, 64'hFFFF8000000000E0},
        // R5 highest canonical low-half address
        '{8'd5, 1'b1,1'b0,1'b0,2'd0,2'd2, 64'h0, 64'h00007FFFFFFFFFFF, 32'h0, 1'b0, 64'h00007FFFFFFFFFFF},
        // R6 absolute with 32-bit size rejected
        '{8'd6, 1'b1,1'b0,1'b0,2'd0,2'd1, 64'h0, 64'h1000, 32'hFFFFFFFF, 1'b1, 64'h00007FFFFFFFFFFF},
        // R6 rel16 rejected
        '{8'd6, 1'b1,1'b0,1'b1,2'd1,2'd2, 64'h1000, 64'h10, 32'hFFFFFFFF, 1'b1, 64'h00007FFFFFFFFFFF},
        // R2 absolute 64 canonical high half
        '{8'd2, 1'b1,1'b0,1'b0,2'd0,2'd2, 64'h0, 64'hFFFFFFFF80000000, 32'h0, 1'b0, 64'hFFFFFFFF80000000},
        // R4 compatibility mode over limit
        '{8'd4, 1'b1,1'b1,1'b0,2'd0,2'd1, 64'h0, 64'h500, 32'h4FF, 1'b1, 64'hFFFFFFFF80000000},
        // R4 compatibility mode relative within limit
        '{8'd4, 1'b1,1'b1,1'b1,2'd2,2'd1, 64'h1000, 64'h10, 32'hFFFF, 1'b0, 64'h1010},
        // R4 64-bit mode ignores limit
        '{8'd4, 1'b1,1'b0,1'b0,2'd0,2'd2, 64'h0, 64'h7000, 32'h0, 1'b0, 64'h7000},
        // R5 bit 47 differs from bits above
        '{8'd5, 1'b1,1'b0,1'b0,2'd0,2'd2, 64'h0, 64'hFFFF7FFFFFFFFFFF, 32'h0, 1'b1, 64'h7000},
        // R7 reserved width in 64-bit mode
        '{8'd7, 1'b1,1'b0,1'b1,2'd3,2'd2, 64'h1000, 64'h10, 32'h0, 1'b1, 64'h7000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_vld = 1'b0;
    logic [63:0] seq_ip = '0;
    logic [63:0] br_operand = '0;
    logic [1:0]  br_osz = '0;
    logic        br_rel = 1'b0;
    logic [1:0]  br_dw = '0;
    logic [31:0] cs_limit = '0;
    logic        long_act = 1'b0;
    logic        compat_act = 1'b0;
    logic [63:0] ip_q;
    logic        ip_commit;
    logic        gp_fault;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nbt_top dut (
        .clk(clk), .rst_n(rst_n), .br_vld(br_vld), .seq_ip(seq_ip),
        .br_operand(br_operand), .br_osz(br_osz), .br_rel(br_rel),
        .br_dw(br_dw), .cs_limit(cs_limit), .long_act(long_act),
        .compat_act(compat_act), .ip_q(ip_q), .ip_commit(ip_commit),
        .gp_fault(gp_fault)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        long_act = v.lm; compat_act = v.cm; br_rel = v.rel; br_dw = v.dw;
        br_osz = v.osz; seq_ip = v.nip; br_operand = v.opnd; cs_limit = v.lim;
        br_vld = 1'b1;
        @(negedge clk);
        br_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ip", ip_q, 64'h0);
        check("R10 flags", {62'h0, ip_commit, gp_fault}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            // outcome registered at the edge between the two negedges
            n_chk++;
            if (ip_q !== VECS[i].xip || gp_fault !== VECS[i].xflt || ip_commit !== !VECS[i].xflt) begin
                n_err++;
                $display("FAIL R%0d vec %0d actual ip=%h flt=%b cmt=%b expected ip=%h flt=%b cmt=%b",
                         VECS[i].req, i, ip_q, gp_fault, ip_commit, VECS[i].xip, VECS[i].xflt, !VECS[i].xflt);
            end
        end

        // R9 no strobe: legal inputs held, nothing moves
        long_act = 1'b0; compat_act = 1'b0; br_rel = 1'b0; br_osz = 2'd1;
        br_operand = 64'h3333; cs_limit = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        check("R9 idle ip", ip_q, 64'h7000);
        check("R9 idle flags", {62'h0, ip_commit, gp_fault}, 64'h0);

        // R9 pulse lasts one cycle
        drive('{8'd9, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0, 64'h3333, 32'hFFFFFFFF, 1'b0, 64'h3333});
        check("R9 commit pulse", {63'h0, ip_commit}, 64'h1);
        @(negedge clk);
        check("R9 pulse end", {62'h0, ip_commit, gp_fault}, 64'h0);
        check("R9 ip kept", ip_q, 64'h3333);

        // R8 fault pulse, ip held
        drive('{8'd8, 1'b0,1'b0,1'b0,2'd0,2'd1, 64'h0, 64'h9000, 32'h8FFF, 1'b1, 64'h3333});
        check("R8 fault", {62'h0, ip_commit, gp_fault}, 64'h1);
        check("R8 ip held", ip_q, 64'h3333);

        // R10 reset mid-run clears pointer
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R10 rerun ip", ip_q, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end
endmodule